// File: doc/BRIEF.md
# Octal DAC Register Bank Controller

This block is the digital register file and update logic for an eight-channel, 12-bit voltage DAC. Writes arrive already deserialised as a 4-bit address plus a 12-bit data word on a valid/ready stream. The block holds eight channel input registers, a global control word, a per-pair control word and a preset word. It drives eight 12-bit converter codes, the power-down and speed controls, and an enable for the readback data output.

An active-low load input decides when the input registers pass to the converter codes. Holding load low makes every write appear immediately. Holding it high freezes the outputs while new values are staged.

An asynchronous active-low preset input forces all eight codes to the preset word at once. Four pair addresses write a value to one channel and its bitwise complement to the neighbour, which gives a differential output. A global mode accepts two's-complement input data and stores it as offset binary.

The write stream never applies back-pressure. `wr_ready` is low during reset and high from the first clock edge after reset. A write is accepted on each rising edge where `wr_valid` and `wr_ready` are both high. The producer may hold `wr_valid` high on consecutive cycles, and each such cycle is a separate write.

Top module: `octal_dac_regbank`

## Requirements
- R1: `wr_ready` is low in reset and high from the first clock edge after reset. A write is taken on every edge where `wr_valid` and `wr_ready` are both high.
- R2: After reset, all eight codes, `pd_all`, `dout_en`, `pair_pd` and `pair_fast` are zero.
- R3: A write to address n (0..7) stores the data for channel n, where channel 0 is the first channel. While `load_n` is low, the new code shows on `dac_code[n]` just after the accepting edge.
- R4: While `load_n` is high and preset is inactive, `dac_code` holds its last transferred values and writes change only the input registers. The next clock edge with `load_n` low transfers them.
- R5: Address 8 is global control. Bit 4 drives `pd_all` (1 = powered down), bit 3 drives `dout_en` (1 = enabled), and bit 0 selects two's-complement input (1) or straight binary (0). The other bits are ignored.
- R6: Address 9 is per-pair control. Bits 4..7 power down pairs 0/1, 2/3, 4/5 and 6/7 (1 = down). Bits 0..3 set the same pairs fast (1) or slow (0); `pair_fast[p]` and `pair_pd[p]` follow bit order.
- R7: `pair_pd[p]` is the OR of that pair's bit and the global power-down bit. Power-down never changes the stored or output codes.
- R8: A write to address 12+p (p = 0..3) stores the data in channel 2p and its bitwise complement in channel 2p+1.
- R9: In two's-complement mode, the data MSB is inverted before storage for channel, pair and preset writes, but not for control writes.
- R10: While `preset_n` is low, every `dac_code` equals the preset word combinationally, whatever `load_n` and writes do.
- R11: The preset word resets to zero. After preset is released, the outputs keep the preset value until a clock edge with `load_n` low comes at least two edges after the release.
- R12: Writes to address 11 change no output and no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted when high |
| wr_addr | input | 4 | Write address |
| wr_data | input | 12 | Write data |
| load_n | input | 1 | Active-low transfer enable |
| preset_n | input | 1 | Active-low asynchronous preset |
| dac_code | output | 8x12 | Converter codes, channel-major packed |
| pd_all | output | 1 | Whole-device power-down |
| pair_pd | output | 4 | Per-pair power-down |
| pair_fast | output | 4 | Per-pair fast speed select |
| dout_en | output | 1 | Readback data output enable |

## Verification
The hardest state to reach from the ports is the hand-back after a preset. The outputs must keep showing the preset word after `preset_n` rises, and return to the staged codes only on a later load-enabled edge.

The stimulus first stages distinct codes with `load_n` low. It then pulses `preset_n` and releases it with `load_n` held high, and watches the outputs stay on the preset value. Only then does it lower `load_n`. The same sequence runs once before any preset write, to expose the zero reset value, and again in two's-complement mode.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;
  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned ADDR_CTRL0 = 8;
  localparam int unsigned ADDR_CTRL1 = 9;
  localparam int unsigned ADDR_PRESET = 10;
  localparam int unsigned ADDR_TWIN  = 12;

  localparam int unsigned C0_PD_BIT   = 4;
  localparam int unsigned C0_DOUT_BIT = 3;
  localparam int unsigned C0_MODE_BIT = 0;

  typedef struct packed {
    logic pd_all;
    logic dout_en;
    logic twos;
  } glob_ctrl_t;
endpackage

// File: rtl/dac_write_decode.sv
module dac_write_decode
  import dac_regbank_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 12
) (
  input  logic                     fire,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DW-1:0]            data,
  input  logic                     twos,
  output logic [NCH-1:0]           code_we,
  output logic [NCH-1:0][DW-1:0]   code_wd,
  output logic                     ctrl0_we,
  output logic                     ctrl1_we,
  output logic                     preset_we,
  output logic [DW-1:0]            preset_wd
);
  localparam logic [DW-1:0] MSB_MASK = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] conv;

  always_comb begin
    conv = twos ? (data ^ MSB_MASK) : data;
  end

  assign ctrl0_we  = fire && (addr == ADDR_W'(ADDR_CTRL0));
  assign ctrl1_we  = fire && (addr == ADDR_W'(ADDR_CTRL1));
  assign preset_we = fire && (addr == ADDR_W'(ADDR_PRESET));
  assign preset_wd = conv;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int unsigned PAIR = ch / 2;
    localparam bit          ODD  = (ch % 2) == 1;
    logic direct_hit;
    logic twin_hit;
    assign direct_hit  = fire && (addr == ADDR_W'(ch));
    assign twin_hit    = fire && (addr == ADDR_W'(ADDR_TWIN + PAIR));
    assign code_we[ch] = direct_hit || twin_hit;
    assign code_wd[ch] = (twin_hit && ODD) ? ~conv : conv;
  end
endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dac_regbank_pkg::*;
#(
  parameter int unsigned NPAIR = 4,
  parameter int unsigned DW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl0_we,
  input  logic             ctrl1_we,
  input  logic [DW-1:0]    data,
  output glob_ctrl_t       glob,
  output logic [NPAIR-1:0] pair_pd,
  output logic [NPAIR-1:0] pair_fast
);
  logic [NPAIR-1:0] pd_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob      <= '0;
      pd_bits   <= '0;
      pair_fast <= '0;
    end else begin
      if (ctrl0_we) begin
        glob.pd_all  <= data[C0_PD_BIT];
        glob.dout_en <= data[C0_DOUT_BIT];
        glob.twos    <= data[C0_MODE_BIT];
      end
      if (ctrl1_we) begin
        pd_bits   <= data[2*NPAIR-1:NPAIR];
        pair_fast <= data[NPAIR-1:0];
      end
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pd
    assign pair_pd[p] = pd_bits[p] | glob.pd_all;
  end
endmodule

// File: rtl/dac_code_bank.sv
module dac_code_bank #(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         code_we,
  input  logic [NCH-1:0][DW-1:0] code_wd,
  input  logic                   preset_we,
  input  logic [DW-1:0]          preset_wd,
  input  logic                   load_n,
  input  logic                   preset_n,
  input  logic                   preset_sync,
  output logic [NCH-1:0][DW-1:0] dac_code
);
  logic [DW-1:0] preset_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         preset_q <= '0;
    else if (preset_we) preset_q <= preset_wd;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0] in_q;
    logic [DW-1:0] in_next;
    logic [DW-1:0] out_q;

    assign in_next = code_we[ch] ? code_wd[ch] : in_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q  <= '0;
        out_q <= '0;
      end else begin
        in_q <= in_next;
        if (!preset_sync) out_q <= preset_q;
        else if (!load_n) out_q <= in_next;
      end
    end

    assign dac_code[ch] = preset_n ? out_q : preset_q;
  end
endmodule

// File: rtl/octal_dac_regbank.sv
module octal_dac_regbank
  import dac_regbank_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic                   load_n,
  input  logic                   preset_n,
  output logic [NCH-1:0][DW-1:0] dac_code,
  output logic                   pd_all,
  output logic [NCH/2-1:0]       pair_pd,
  output logic [NCH/2-1:0]       pair_fast,
  output logic                   dout_en
);
  localparam int unsigned NPAIR = NCH / 2;

  logic                   fire;
  logic [1:0]             psync_ff;
  logic                   preset_sync;
  glob_ctrl_t             glob;
  logic [NCH-1:0]         code_we;
  logic [NCH-1:0][DW-1:0] code_wd;
  logic                   ctrl0_we;
  logic                   ctrl1_we;
  logic                   preset_we;
  logic [DW-1:0]          preset_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ready <= 1'b0;
    else        wr_ready <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psync_ff <= 2'b11;
    else        psync_ff <= {psync_ff[0], preset_n};
  end

  assign preset_sync = psync_ff[1];
  assign fire        = wr_valid && wr_ready;

  dac_write_decode #(.NCH(NCH), .DW(DW)) i_decode (
    .fire      (fire),
    .addr      (wr_addr),
    .data      (wr_data),
    .twos      (glob.twos),
    .code_we   (code_we),
    .code_wd   (code_wd),
    .ctrl0_we  (ctrl0_we),
    .ctrl1_we  (ctrl1_we),
    .preset_we (preset_we),
    .preset_wd (preset_wd)
  );

  dac_ctrl_regs #(.NPAIR(NPAIR), .DW(DW)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl0_we  (ctrl0_we),
    .ctrl1_we  (ctrl1_we),
    .data      (wr_data),
    .glob      (glob),
    .pair_pd   (pair_pd),
    .pair_fast (pair_fast)
  );

  dac_code_bank #(.NCH(NCH), .DW(DW)) i_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .code_we     (code_we),
    .code_wd     (code_wd),
    .preset_we   (preset_we),
    .preset_wd   (preset_wd),
    .load_n      (load_n),
    .preset_n    (preset_n),
    .preset_sync (preset_sync),
    .dac_code    (dac_code)
  );

  assign pd_all  = glob.pd_all;
  assign dout_en = glob.dout_en;
endmodule

// File: rtl/dac_regbank_checker.sv
module dac_regbank_checker #(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_valid,
  input logic                   wr_ready,
  input logic [3:0]             wr_addr,
  input logic [DW-1:0]          wr_data,
  input logic                   load_n,
  input logic                   preset_n,
  input logic                   preset_sync,
  input logic [NCH-1:0][DW-1:0] dac_code,
  input logic                   pd_all,
  input logic [NCH/2-1:0]       pair_pd,
  input logic [NCH/2-1:0]       pair_fast,
  input logic                   dout_en
);
  logic fire;
  assign fire = wr_valid && wr_ready;

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wr_ready); // R1

  AST_HOLD_WHEN_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && preset_n && preset_sync) |=> (!preset_n || $stable(dac_code))); // R4

  AST_CTRL0_PD_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_addr == 4'd8) |=> (pd_all == $past(wr_data[4]))); // R5

  AST_GLOBAL_PD_ALL_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    pd_all |-> (&pair_pd)); // R7

  AST_TWIN_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_addr[3:2] == 2'b11 && !load_n && preset_sync && preset_n) |=>
    (!preset_n || dac_code[{$past(wr_addr[1:0]), 1'b1}] ==
                  ~dac_code[{$past(wr_addr[1:0]), 1'b0}])); // R8

  AST_PRESET_ALL_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_n |-> (dac_code == {NCH{dac_code[0]}})); // R10

  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_addr == 4'd11) |=>
    ($stable(pd_all) && $stable(dout_en) && $stable(pair_pd) && $stable(pair_fast))); // R12
endmodule

bind octal_dac_regbank dac_regbank_checker #(.NCH(NCH), .DW(DW)) i_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .load_n      (load_n),
  .preset_n    (preset_n),
  .preset_sync (preset_sync),
  .dac_code    (dac_code),
  .pd_all      (pd_all),
  .pair_pd     (pair_pd),
  .pair_fast   (pair_fast),
  .dout_en     (dout_en)
);

// File: tb/test_octal_dac_regbank.sv
module test_octal_dac_regbank;
  localparam int NCH = 8;
  localparam int DW  = 12;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   wr_valid = 1'b0;
  logic                   wr_ready;
  logic [3:0]             wr_addr = '0;
  logic [DW-1:0]          wr_data = '0;
  logic                   load_n = 1'b0;
  logic                   preset_n = 1'b1;
  logic [NCH-1:0][DW-1:0] dac_code;
  logic                   pd_all;
  logic [NCH/2-1:0]       pair_pd;
  logic [NCH/2-1:0]       pair_fast;
  logic                   dout_en;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  octal_dac_regbank #(.NCH(NCH), .DW(DW)) i_octal_dac_regbank (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .load_n(load_n), .preset_n(preset_n),
    .dac_code(dac_code), .pd_all(pd_all), .pair_pd(pair_pd),
    .pair_fast(pair_fast), .dout_en(dout_en)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R2", "codes after reset", 32'(dac_code == '0), 32'd1);
    check("R2", "pd_all", 32'(pd_all), 32'd0);
    check("R2", "pair_pd", 32'(pair_pd), 32'd0);
    check("R2", "pair_fast", 32'(pair_fast), 32'd0);
    check("R2", "dout_en", 32'(dout_en), 32'd0);
    check("R1", "wr_ready after reset", 32'(wr_ready), 32'd1);
  endtask

  task automatic t_direct;
    load_n = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      wr(4'(c), 12'(12'h100 + c * 12'h011));
      check("R3", $sformatf("ch%0d direct", c), 32'(dac_code[c]), 32'(12'h100 + c * 12'h011));
    end
  endtask

  task automatic t_preset_default;
    @(negedge clk);
    preset_n = 1'b0;
    #1;
    check("R11", "unwritten preset gives zero", 32'(dac_code == '0), 32'd1);
    @(negedge clk);
    load_n = 1'b1;
    idle(2);
    preset_n = 1'b1;
    idle(4);
    check("R11", "zero held after release", 32'(dac_code[0]), 32'h0);
    load_n = 1'b0;
    idle(1);
    check("R11", "ch0 back after load", 32'(dac_code[0]), 32'h100);
    check("R11", "ch7 back after load", 32'(dac_code[7]), 32'h177);
  endtask

  task automatic t_load_hold;
    load_n = 1'b1;
    wr(4'd2, 12'hABC);
    idle(1);
    check("R4", "ch2 held while load high", 32'(dac_code[2]), 32'h122);
    load_n = 1'b0;
    idle(1);
    check("R4", "ch2 after load low", 32'(dac_code[2]), 32'hABC);
  endtask

  task automatic t_pair;
    wr(4'd13, 12'hFFF);
    check("R8", "ch2 pair write", 32'(dac_code[2]), 32'hFFF);
    check("R8", "ch3 complement", 32'(dac_code[3]), 32'h000);
    wr(4'd12, 12'h123);
    check("R8", "ch0 pair write", 32'(dac_code[0]), 32'h123);
    check("R8", "ch1 complement", 32'(dac_code[1]), 32'hEDC);
    check("R8", "ch4 untouched", 32'(dac_code[4]), 32'h144);
  endtask

  task automatic t_ctrl;
    wr(4'd8, 12'h019);
    check("R5", "pd_all set", 32'(pd_all), 32'd1);
    check("R5", "dout_en set", 32'(dout_en), 32'd1);
    check("R7", "global pd all pairs", 32'(pair_pd), 32'hF);
    check("R7", "codes kept in pd", 32'(dac_code[0]), 32'h123);
    wr(4'd8, 12'h000);
    wr(4'd9, 12'h05A);
    check("R6", "pair_pd bits", 32'(pair_pd), 32'h5);
    check("R6", "pair_fast bits", 32'(pair_fast), 32'hA);
    wr(4'd8, 12'h010);
    check("R7", "or with global", 32'(pair_pd), 32'hF);
    wr(4'd8, 12'h000);
    check("R7", "own bits return", 32'(pair_pd), 32'h5);
  endtask

  task automatic t_reserved;
    wr(4'd11, 12'hFFF);
    idle(1);
    check("R12", "pair_pd kept", 32'(pair_pd), 32'h5);
    check("R12", "pd_all kept", 32'(pd_all), 32'd0);
    check("R12", "dout_en kept", 32'(dout_en), 32'd0);
    check("R12", "ch0 kept", 32'(dac_code[0]), 32'h123);
    check("R12", "ch7 kept", 32'(dac_code[7]), 32'h177);
  endtask

  task automatic t_twos;
    wr(4'd8, 12'h001);
    check("R9", "mode not converted on control", 32'(pd_all), 32'd0);
    wr(4'd4, 12'h000);
    check("R9", "ch4 msb flipped", 32'(dac_code[4]), 32'h800);
    wr(4'd14, 12'h7FF);
    check("R9", "ch4 pair converted", 32'(dac_code[4]), 32'hFFF);
    check("R9", "ch5 pair complement", 32'(dac_code[5]), 32'h000);
    wr(4'd10, 12'h000);
    @(negedge clk);
    preset_n = 1'b0;
    #1;
    check("R9", "preset converted", 32'(dac_code[6]), 32'h800);
    idle(2);
    preset_n = 1'b1;
    idle(4);
    check("R9", "ch6 restored", 32'(dac_code[6]), 32'h166);
    wr(4'd8, 12'h000);
  endtask

  task automatic t_preset;
    wr(4'd10, 12'h5A5);
    @(negedge clk);
    preset_n = 1'b0;
    #1;
    for (int c = 0; c < NCH; c++)
      check("R10", $sformatf("ch%0d preset", c), 32'(dac_code[c]), 32'h5A5);
    wr(4'd7, 12'h001);
    idle(1);
    check("R10", "preset beats load", 32'(dac_code[7]), 32'h5A5);
    preset_n = 1'b1;
    idle(4);
    check("R10", "ch7 after release", 32'(dac_code[7]), 32'h001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_direct();
    t_preset_default();
    t_load_hold();
    t_pair();
    t_ctrl();
    t_reserved();
    t_twos();
    t_preset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule